// File: doc/BRIEF.md
# Bipolar Line Encoder with Zero Substitution

This block turns a unipolar serial bit stream into the two pulse rails that drive a bipolar line interface. A one becomes a mark on the positive or negative rail, with marks alternating in polarity; a zero becomes no pulse. Long runs of zeros are replaced by a code word that contains a deliberate polarity violation, so the far end keeps clock recovery. Three-zero substitution is used for the lower-rate electrical mode and four-zero substitution for the higher-order European mode. The substitution can also be switched off so that the line carries plain alternate mark inversion.

A select input lets a second serial source feed the encoder in place of the framed data. A test input forces a line code violation onto the stream. The selected unencoded bit is brought out, registered, as a monitor. The encoder sees a fixed number of upcoming bits in a short delay line before it commits to a symbol. This gives a constant four-cycle latency from input to line rails in every mode.

Top module: `lenc_bipolar_top`

## Requirements
- R1: While `rst_n` is low, `line_pos`, `line_neg` and `nrz_mon` are low. Reset clears the substitution parity to even and sets the polarity state so that the first mark after reset goes out on `line_pos`.
- R2: The symbol for an input bit appears on the rails after the fourth rising edge, counting the edge that samples the bit as the first. No symbol is ever emitted for the bits held in the pipeline at reset.
- R3: `line_pos` and `line_neg` are never high together. Both are registered, so each pulse lasts whole clock periods and changes only at a rising edge.
- R4: With `ami_sel` high, every one gives a mark with the opposite polarity of the previous mark, and every zero gives no pulse on either rail.
- R5: With `ami_sel` low and `hdb3_sel` low, each run of three zeros is sent as B0V if the number of marks since the last substitution is even, and as 00V if it is odd. The output never holds three symbol periods of silence in a row.
- R6: With `ami_sel` low and `hdb3_sel` high, each run of four zeros is sent as B00V if the mark count since the last substitution is even, and as 000V if it is odd. The output never holds four silent periods in a row.
- R7: A B pulse takes the opposite polarity of the preceding pulse. A V pulse repeats the polarity of the preceding pulse. The mark count resets to even at every V, and it includes injected violations.
- R8: A high `inject_lcv` sampled with bit k makes the first data mark at or after bit k repeat the previous pulse polarity. Later marks alternate from that pulse. Substitution pulses are not altered.
- R9: With `use_direct` high, `direct_in` is encoded and `nrz_in` has no effect on the rails or the monitor. With `use_direct` low, the roles are swapped.
- R10: `nrz_mon` shows, one edge later, the selected unencoded bit sampled at each rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdb3_sel | input | 1 | 0: three-zero substitution, 1: four-zero substitution |
| ami_sel | input | 1 | 1: plain alternate mark inversion, no substitution |
| use_direct | input | 1 | 1: encode `direct_in` instead of `nrz_in` |
| nrz_in | input | 1 | Framed serial data |
| direct_in | input | 1 | Alternate serial data for the encoder |
| inject_lcv | input | 1 | Force a violation on the next data mark |
| line_pos | output | 1 | Positive rail pulse |
| line_neg | output | 1 | Negative rail pulse |
| nrz_mon | output | 1 | Registered copy of the selected unencoded bit |

## Verification
The checker watches, on every cycle, that the rails are never both high and that the monitor follows the selected input. It also checks that, in the pass-through mode, pulse presence matches the input delayed by the latency. In both substitution modes it checks that no silent stretch reaches the substitution run length. Exact polarity patterns need the bench's scenarios: B versus V choice, parity reset after V, the placement of an injected violation, the first mark after reset and the exact latency. The bench compares these, bit by bit, with an independent model.

// File: rtl/lenc_pkg.sv
package lenc_pkg;
   // zero-run lengths that trigger substitution
   localparam int B3ZS_RUN = 3;
   localparam int HDB3_RUN = 4;
   // width of the substitution position counter
   localparam int RUN_W    = $clog2(HDB3_RUN + 1);
endpackage

// File: rtl/lenc_src_sel.sv
module lenc_src_sel (
   input  logic clk,
   input  logic rst_n,
   input  logic use_direct,
   input  logic nrz_in,
   input  logic direct_in,
   output logic src_bit,
   output logic mon_q
);
   assign src_bit = use_direct ? direct_in : nrz_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mon_q <= 1'b0;
      else        mon_q <= src_bit;
   end
endmodule

// File: rtl/lenc_delay.sv
module lenc_delay #(
   parameter int STAGES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din,
   input  logic              inj_in,
   output logic [STAGES-1:0] data_q,
   output logic              inj_head,
   output logic              vld_head
);
   logic [STAGES-1:0] inj_q;
   logic [STAGES-1:0] vld_q;

   // index 0 is the youngest bit, STAGES-1 the bit being encoded
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         inj_q  <= '0;
         vld_q  <= '0;
      end else begin
         data_q[0] <= din;
         inj_q[0]  <= inj_in;
         vld_q[0]  <= 1'b1;
         for (int k = 1; k < STAGES; k++) begin
            data_q[k] <= data_q[k-1];
            inj_q[k]  <= inj_q[k-1];
            vld_q[k]  <= vld_q[k-1];
         end
      end
   end

   assign inj_head = inj_q[STAGES-1];
   assign vld_head = vld_q[STAGES-1];
endmodule

// File: rtl/lenc_subst.sv
module lenc_subst
   import lenc_pkg::*;
#(
   parameter int STAGES = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hdb3_sel,
   input  logic            ami_sel,
   input  logic            vld_head,
   input  logic            inj_head,
   input  logic [STAGES:0] win,
   output logic            line_pos,
   output logic            line_neg
);
   logic [RUN_W-1:0] left_q, left_n, run_len;
   logic last_q, last_n;   // 1: last pulse was positive
   logic par_q, par_n;     // 1: odd mark count since last V
   logic pend_q, pend_n;   // violation waiting for a data mark
   logic pos_n, neg_n;
   logic zrun, head;

   assign head    = win[STAGES];
   assign run_len = hdb3_sel ? RUN_W'(HDB3_RUN) : RUN_W'(B3ZS_RUN);
   assign zrun    = hdb3_sel ? ~|win[STAGES -: HDB3_RUN] : ~|win[STAGES -: B3ZS_RUN];

   always_comb begin
      left_n = left_q;
      last_n = last_q;
      par_n  = par_q;
      pend_n = pend_q;
      pos_n  = 1'b0;
      neg_n  = 1'b0;
      if (vld_head) begin
         pend_n = pend_q | inj_head;
         if (left_q != '0) begin
            // inside a code word: zeros, then V on the last slot
            left_n = left_q - RUN_W'(1);
            if (left_q == RUN_W'(1)) begin
               pos_n = last_q;
               neg_n = !last_q;
               par_n = 1'b0;
            end
         end else if (!ami_sel && zrun) begin
            left_n = run_len - RUN_W'(1);
            if (!par_q) begin
               pos_n  = !last_q;
               neg_n  = last_q;
               last_n = !last_q;
            end
         end else if (head) begin
            if (pend_n) begin
               pos_n  = last_q;
               neg_n  = !last_q;
               pend_n = 1'b0;
            end else begin
               pos_n  = !last_q;
               neg_n  = last_q;
               last_n = !last_q;
            end
            par_n = !par_q;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q   <= '0;
         last_q   <= 1'b0;
         par_q    <= 1'b0;
         pend_q   <= 1'b0;
         line_pos <= 1'b0;
         line_neg <= 1'b0;
      end else begin
         left_q   <= left_n;
         last_q   <= last_n;
         par_q    <= par_n;
         pend_q   <= pend_n;
         line_pos <= pos_n;
         line_neg <= neg_n;
      end
   end
endmodule

// File: rtl/lenc_bipolar_top.sv
module lenc_bipolar_top
   import lenc_pkg::*;
#(
   parameter int LATENCY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hdb3_sel,
   input  logic ami_sel,
   input  logic use_direct,
   input  logic nrz_in,
   input  logic direct_in,
   input  logic inject_lcv,
   output logic line_pos,
   output logic line_neg,
   output logic nrz_mon
);
   localparam int STAGES = LATENCY - 1;

   // the look-ahead window must cover the longest zero run
   if (STAGES < HDB3_RUN - 1) begin : g_bad_latency
      $error("LATENCY too small for four-zero look-ahead");
   end

   logic              src_bit;
   logic [STAGES-1:0] data_q;
   logic              inj_head, vld_head;
   logic [STAGES:0]   win;

   lenc_src_sel u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .use_direct (use_direct),
      .nrz_in     (nrz_in),
      .direct_in  (direct_in),
      .src_bit    (src_bit),
      .mon_q      (nrz_mon)
   );

   lenc_delay #(.STAGES(STAGES)) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (src_bit),
      .inj_in   (inject_lcv),
      .data_q   (data_q),
      .inj_head (inj_head),
      .vld_head (vld_head)
   );

   assign win = {data_q, src_bit};

   lenc_subst #(.STAGES(STAGES)) u_enc (
      .clk      (clk),
      .rst_n    (rst_n),
      .hdb3_sel (hdb3_sel),
      .ami_sel  (ami_sel),
      .vld_head (vld_head),
      .inj_head (inj_head),
      .win      (win),
      .line_pos (line_pos),
      .line_neg (line_neg)
   );
endmodule

// File: rtl/lenc_checker.sv
module lenc_checker
   import lenc_pkg::*;
#(
   parameter int LATENCY = 4
) (
   input logic clk,
   input logic rst_n,
   input logic hdb3_sel,
   input logic ami_sel,
   input logic src_bit,
   input logic line_pos,
   input logic line_neg,
   input logic nrz_mon
);
   localparam int CW = $clog2(LATENCY + 1);

   logic [CW-1:0]      age;
   logic               warm;
   logic [LATENCY-1:0] dly;
   logic [RUN_W-1:0]   zrun_q, zrun_c;

   assign warm   = (age == CW'(LATENCY));
   assign zrun_c = (line_pos | line_neg) ? '0 :
                   (zrun_q == '1) ? zrun_q : zrun_q + RUN_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age    <= '0;
         dly    <= '0;
         zrun_q <= '0;
      end else begin
         if (!warm) age <= age + CW'(1);
         dly    <= {dly[LATENCY-2:0], src_bit};
         zrun_q <= warm ? zrun_c : '0;
      end
   end

   assert_rails_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({line_pos, line_neg}));

   assert_monitor_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (nrz_mon == $past(src_bit)));

   assert_ami_mapping_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && ami_sel) |-> ((line_pos | line_neg) == dly[LATENCY-1]));

   assert_zero_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && !ami_sel && !hdb3_sel) |-> (zrun_c < RUN_W'(B3ZS_RUN)));

   assert_zero_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && !ami_sel && hdb3_sel) |-> (zrun_c < RUN_W'(HDB3_RUN)));
endmodule

bind lenc_bipolar_top lenc_checker #(.LATENCY(LATENCY)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hdb3_sel (hdb3_sel),
   .ami_sel  (ami_sel),
   .src_bit  (src_bit),
   .line_pos (line_pos),
   .line_neg (line_neg),
   .nrz_mon  (nrz_mon)
);

// File: tb/sim_lenc_bipolar_top.sv
`timescale 1ns/1ps
module sim_lenc_bipolar_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hdb3_sel = 1'b0, ami_sel = 1'b0, use_direct = 1'b0;
   logic nrz_in = 1'b0, direct_in = 1'b0, inject_lcv = 1'b0;
   logic line_pos, line_neg, nrz_mon;

   int total = 0;
   int fails = 0;
   bit done = 0;

   localparam int NB = 48;   // bits driven per run
   localparam int NC = 40;   // bits checked per run

   logic ep [NB];
   logic en [NB];
   logic [1:0] gotc [NB+4];

   // {hdb3, ami, pattern LSB first}
   localparam logic [33:0] TBL [9] = '{
      {1'b0, 1'b0, 32'h0000_0001},
      {1'b0, 1'b0, 32'hF0F0_0F0F},
      {1'b0, 1'b0, 32'h1248_0000},
      {1'b0, 1'b0, 32'h0000_0000},
      {1'b1, 1'b0, 32'h0000_0001},
      {1'b1, 1'b0, 32'h8100_0C31},
      {1'b1, 1'b0, 32'hFFFF_0000},
      {1'b0, 1'b1, 32'hA5A5_0003},
      {1'b0, 1'b1, 32'h0000_0000}
   };

   always #4 clk = ~clk;

   lenc_bipolar_top u0 (
      .clk(clk), .rst_n(rst_n), .hdb3_sel(hdb3_sel), .ami_sel(ami_sel),
      .use_direct(use_direct), .nrz_in(nrz_in), .direct_in(direct_in),
      .inject_lcv(inject_lcv), .line_pos(line_pos), .line_neg(line_neg),
      .nrz_mon(nrz_mon)
   );

   task automatic check(input bit ok, input string tag, input int got, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
      end
   endtask

   // reference encoder written from the requirements
   task automatic model(input logic [NB-1:0] b, input logic h, input logic a, input int inj);
      int  i, run;
      logic last, par, pend, allz, pol;
      run = h ? 4 : 3;
      last = 1'b0; par = 1'b0; pend = 1'b0;
      for (int k = 0; k < NB; k++) begin ep[k] = 1'b0; en[k] = 1'b0; end
      i = 0;
      while (i < NB) begin
         allz = 1'b1;
         for (int k = 0; k < run; k++) if (i + k < NB && b[i+k]) allz = 1'b0;
         if (!a && allz) begin
            for (int k = 0; k < run; k++) if (i + k == inj) pend = 1'b1;
            if (!par) begin
               last = !last;
               ep[i] = last; en[i] = !last;
            end
            if (i + run - 1 < NB) begin
               ep[i+run-1] = last; en[i+run-1] = !last;
            end
            par = 1'b0;
            i = i + run;
         end else begin
            if (i == inj) pend = 1'b1;
            if (b[i]) begin
               if (pend) begin pol = last; pend = 1'b0; end
               else begin last = !last; pol = last; end
               ep[i] = pol; en[i] = !pol;
               par = !par;
            end
            i++;
         end
      end
   endtask

   task automatic run_stream(input logic h, input logic a, input logic d,
                             input logic [NB-1:0] b, input int inj,
                             input bit use_model, input string tag);
      @(negedge clk);
      rst_n = 1'b0;
      hdb3_sel = h; ami_sel = a; use_direct = d;
      nrz_in = 1'b0; direct_in = 1'b0; inject_lcv = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      if (use_model) model(b, h, a, inj);
      for (int c = 0; c < NB + 4; c++) begin
         gotc[c] = {line_pos, line_neg};
         if (use_model && c >= 4 && c - 4 < NC)
            check({line_pos, line_neg} == {ep[c-4], en[c-4]}, tag,
                  int'({line_pos, line_neg}), int'({ep[c-4], en[c-4]}));
         if (c >= 1 && c - 1 < NB)
            check(nrz_mon == b[c-1], "R10 monitor", int'(nrz_mon), int'(b[c-1]));
         if (c < NB) begin
            if (d) begin direct_in = b[c]; nrz_in = ~b[c]; end
            else   begin nrz_in = b[c]; direct_in = ~b[c]; end
         end else begin
            nrz_in = 1'b0; direct_in = 1'b0;
         end
         inject_lcv = (c == inj);
         @(negedge clk);
      end
   endtask

   localparam logic [1:0] P = 2'b10, N = 2'b01, Z = 2'b00;

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check({line_pos, line_neg, nrz_mon} == 3'b000, "R1 reset outputs",
            int'({line_pos, line_neg, nrz_mon}), 0);

      // table-driven streams against the model
      for (int t = 0; t < 9; t++) begin
         string tag;
         tag = TBL[t][32] ? "R4 AMI" : (TBL[t][33] ? "R6 four-zero" : "R5 three-zero");
         run_stream(TBL[t][33], TBL[t][32], 1'b0, {16'h0, TBL[t][31:0]}, -1, 1'b1, tag);
      end

      // R1 R5: zeros from reset give B0V twice, first B positive
      run_stream(1'b0, 1'b0, 1'b0, '0, -1, 1'b0, "");
      check({gotc[4], gotc[5], gotc[6]} == {P, Z, P}, "R1/R5 first B0V",
            int'({gotc[4], gotc[5], gotc[6]}), int'({P, Z, P}));
      check({gotc[7], gotc[8], gotc[9]} == {N, Z, N}, "R5/R7 second B0V",
            int'({gotc[7], gotc[8], gotc[9]}), int'({N, Z, N}));

      // R6 R7: mark then odd count gives 000V with V repeating polarity
      run_stream(1'b1, 1'b0, 1'b0, 48'h1, -1, 1'b0, "");
      check({gotc[4], gotc[5], gotc[6], gotc[7], gotc[8]} == {P, Z, Z, Z, P}, "R6/R7 000V",
            int'({gotc[4], gotc[5], gotc[6], gotc[7], gotc[8]}), int'({P, Z, Z, Z, P}));

      // R6 R7: two marks then even count gives B00V
      run_stream(1'b1, 1'b0, 1'b0, 48'h3, -1, 1'b0, "");
      check({gotc[4], gotc[5], gotc[6], gotc[7], gotc[8], gotc[9]} == {P, N, P, Z, Z, P},
            "R6/R7 B00V",
            int'({gotc[4], gotc[5], gotc[6], gotc[7], gotc[8], gotc[9]}),
            int'({P, N, P, Z, Z, P}));

      // R2 R8: AMI ones with injection at bit 2, latency visible at c=3/4
      run_stream(1'b0, 1'b1, 1'b0, 48'hF, 2, 1'b0, "");
      check(gotc[3] == Z, "R2 no symbol before latency", int'(gotc[3]), int'(Z));
      check({gotc[4], gotc[5], gotc[6], gotc[7]} == {P, N, N, P}, "R2/R8 AMI injection",
            int'({gotc[4], gotc[5], gotc[6], gotc[7]}), int'({P, N, N, P}));

      // R8 R7: injected mark counts toward parity before a three-zero run
      run_stream(1'b0, 1'b0, 1'b0, 48'h3, 1, 1'b0, "");
      check({gotc[4], gotc[5], gotc[6], gotc[7], gotc[8]} == {P, P, N, Z, N},
            "R8/R7 injection then B0V",
            int'({gotc[4], gotc[5], gotc[6], gotc[7], gotc[8]}), int'({P, P, N, Z, N}));

      // R9: direct input encoded, nrz_in inverted and ignored
      run_stream(1'b0, 1'b1, 1'b1, 48'h5, -1, 1'b0, "");
      check({gotc[4], gotc[5], gotc[6], gotc[7]} == {P, Z, N, Z}, "R9 direct source",
            int'({gotc[4], gotc[5], gotc[6], gotc[7]}), int'({P, Z, N, Z}));

      // R9: direct selected with model across a substitution stream
      run_stream(1'b1, 1'b0, 1'b1, 48'h0000_9C01_0031, -1, 1'b1, "R9 direct four-zero");

      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule